// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor core's exception logic and decides, for every exception or debug event, whether the core drops into debug mode or takes the event as an ordinary interrupt. Each event request is first qualified by the machine-state condition that applies to it. The recognized event with the highest priority then wins the cycle. Its per-event enable bit and a global debug switch decide which of two one-cycle strobes fires. The winning event's bit is latched into a cause register, which software clears by writing ones.

A reset counts as an event of its own. After the reset input falls, the block counts a fixed window of cycles. On the last cycle of that window it looks at a debug-request pin. If the pin is high, the core enters debug mode instead of fetching from the reset vector, and a dedicated cause bit records that the entry came from the pin. A freeze output tells the surrounding modules to halt whenever an enabled event is taken, whether or not debug mode itself is switched on. An exit input ends debug mode and drops freeze.

Top module: `dbg_entry_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, all strobes, freeze, debug-active, the non-restartable flag and the cause register are 0, and the per-event enable register reads all ones.
- R2: Event 0 (reset) is raised internally in the 7th cycle after reset negates. One cycle later, with the pin high, the enable bit set and global debug on, `dbg_entry` pulses and cause bits 0 and 31 are set. With the pin low, `int_take` pulses and only cause bit 0 is set. There is no second reset event.
- R3: A taken event pulses `dbg_entry` one cycle later only if `glob_en` is 1 and the event's bit in `der_q` is 1. Otherwise it pulses `int_take`. `der_q` bit i belongs to event i.
- R4: `freeze` rises one cycle after a taken event whose `der_q` bit is set, regardless of `glob_en`, and it stays high until an exit.
- R5: External (event 8) and decrementer (event 12) requests are ignored while `msr_ee` is 0.
- R6: Instruction breakpoint (event 16) and load/store breakpoint (event 17) are ignored only when `bk_masked` is 1 and `msr_ri` is 0.
- R7: Peripheral breakpoint (event 18) is ignored while `msr_ri` is 0.
- R8: The non-maskable request (event 1) is recognized regardless of `msr_ri`. When it enters debug mode, `unrecov` goes high and stays high until exit.
- R9: Among recognized events in one cycle, the lowest index wins. The event order is 0 reset, 1 non-maskable request, 2 check stop, 3 machine check, 4/5 instruction TLB miss/error, 6/7 data TLB miss/error, 8 external, 9 alignment, 10 program, 11 FP unavailable, 12 decrementer, 13 system call, 14 trace, 15 software emulation, 16/17/18 breakpoints. Only the winner's cause bit is set, and at most one strobe fires.
- R10: `exit_dbg` clears `dbg_active`, `freeze` and `unrecov` on the next edge.
- R11: Cause bits set in `cause_clr` are cleared on the next edge. A bit being set in the same cycle stays set.
- R12: While `dbg_active` or `exit_dbg` is 1, events are not arbitrated: no strobe fires and the cause register does not change.
- R13: A write through `der_wr`/`der_wdata` replaces `der_q` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req | input | 18 | Event requests 1..18 (bit k is event k+1) |
| msr_ee | input | 1 | External-interrupt enable state bit |
| msr_ri | input | 1 | Recoverable-interrupt state bit |
| bk_masked | input | 1 | Breakpoints masked |
| glob_en | input | 1 | Global debug-mode enable |
| dbg_pin | input | 1 | Debug-request pin sampled after reset |
| der_wr | input | 1 | Enable register write strobe |
| der_wdata | input | 19 | Enable register write data |
| exit_dbg | input | 1 | Leave debug mode |
| cause_clr | input | 32 | Write-one-to-clear mask for the cause register |
| dbg_entry | output | 1 | One-cycle debug entry strobe |
| int_take | output | 1 | One-cycle normal interrupt strobe |
| freeze | output | 1 | Halt indication for other modules |
| dbg_active | output | 1 | Core is in debug mode |
| unrecov | output | 1 | Debug entered through the non-maskable request |
| der_q | output | 19 | Per-event enable register |
| cause | output | 32 | Latched cause bits |

## Verification
The cause register can be set by the winning event and cleared by the write-one-to-clear mask on the same edge. The bench provokes this by first latching a check-stop bit. On the next cycle it raises a system-call request while writing ones to every cause bit. The result must hold only the system-call bit: the old bit is cleared and the new bit survives. A second pairing has event arbitration meeting the exit input or debug-active state in the same cycle. There, a non-maskable request presented while debug is active must leave both strobes and the cause register untouched.

// File: rtl/dbgent_pkg.sv
package dbgent_pkg;
    localparam int NEV   = 19;
    localparam int IDX_W = $clog2(NEV);

    typedef enum logic [IDX_W-1:0] {
        EV_RST = 0, EV_NMI, EV_CHKSTOP, EV_MCHK,
        EV_ITLB_MISS, EV_ITLB_ERR, EV_DTLB_MISS, EV_DTLB_ERR,
        EV_EXT, EV_ALIGN, EV_PROG, EV_FPU, EV_DEC, EV_SYSC,
        EV_TRACE, EV_SWEMU, EV_IBRK, EV_LSBRK, EV_PBRK
    } ev_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Machine-state qualification of one event index.
    function automatic logic ev_allowed(input int idx, input logic ee,
                                        input logic ri, input logic bkm);
        if (idx == int'(EV_EXT) || idx == int'(EV_DEC))
            return ee;
        if (idx == int'(EV_IBRK) || idx == int'(EV_LSBRK))
            return ri || !bkm;
        if (idx == int'(EV_PBRK))
            return ri;
        return 1'b1;
    endfunction
endpackage

// File: rtl/dbgent_rst_window.sv
module dbgent_rst_window #(
    parameter int WIN = 7
) (
    input  logic clk,
    input  logic rst,
    output logic rst_evt
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt < CW'(WIN))
            cnt <= cnt + 1'b1;
    end

    assign rst_evt = !rst && (cnt == CW'(WIN - 1));
endmodule

// File: rtl/dbgent_pick.sv
module dbgent_pick
    import dbgent_pkg::*;
(
    input  logic [NEV-1:0] raw,
    input  logic           ee,
    input  logic           ri,
    input  logic           bk_masked,
    output pick_t          pick
);
    logic [NEV-1:0] recog;

    generate
        for (genvar i = 0; i < NEV; i++) begin : g_qual
            assign recog[i] = raw[i] && ev_allowed(i, ee, ri, bk_masked);
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int i = NEV - 1; i >= 0; i--) begin
            if (recog[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl
    import dbgent_pkg::*;
#(
    parameter int WIN_CYC = 7,
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NEV-2:0]     ev_req,
    input  logic               msr_ee,
    input  logic               msr_ri,
    input  logic               bk_masked,
    input  logic               glob_en,
    input  logic               dbg_pin,
    input  logic               der_wr,
    input  logic [NEV-1:0]     der_wdata,
    input  logic               exit_dbg,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic               dbg_entry,
    output logic               int_take,
    output logic               freeze,
    output logic               dbg_active,
    output logic               unrecov,
    output logic [NEV-1:0]     der_q,
    output logic [CAUSE_W-1:0] cause
);
    localparam int PIN_BIT = CAUSE_W - 1;

    logic               rst_evt;
    logic [NEV-1:0]     all_ev;
    pick_t              pick;
    logic               take, en_bit, to_dbg;
    logic [CAUSE_W-1:0] set_mask;

    dbgent_rst_window #(.WIN(WIN_CYC)) u_win (
        .clk    (clk),
        .rst    (rst),
        .rst_evt(rst_evt)
    );

    assign all_ev = {ev_req, rst_evt};

    dbgent_pick u_pick (
        .raw      (all_ev),
        .ee       (msr_ee),
        .ri       (msr_ri),
        .bk_masked(bk_masked),
        .pick     (pick)
    );

    assign take   = pick.valid && !dbg_active && !exit_dbg;
    assign en_bit = der_q[pick.idx] && (pick.idx != EV_RST || dbg_pin);
    assign to_dbg = take && glob_en && en_bit;

    always_comb begin
        set_mask = '0;
        if (take)
            set_mask[pick.idx] = 1'b1;
        if (to_dbg && pick.idx == EV_RST)
            set_mask[PIN_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_entry  <= 1'b0;
            int_take   <= 1'b0;
            freeze     <= 1'b0;
            dbg_active <= 1'b0;
            unrecov    <= 1'b0;
            der_q      <= '1;
            cause      <= '0;
        end else begin
            dbg_entry <= to_dbg;
            int_take  <= take && !to_dbg;
            if (der_wr)
                der_q <= der_wdata;
            if (exit_dbg) begin
                dbg_active <= 1'b0;
                freeze     <= 1'b0;
                unrecov    <= 1'b0;
            end else begin
                if (to_dbg)
                    dbg_active <= 1'b1;
                if (take && en_bit)
                    freeze <= 1'b1;
                if (to_dbg && pick.idx == EV_NMI)
                    unrecov <= 1'b1;
            end
            cause <= (cause & ~cause_clr) | set_mask;
        end
    end
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk (
    input logic clk,
    input logic rst,
    input logic glob_en,
    input logic exit_dbg,
    input logic dbg_entry,
    input logic int_take,
    input logic freeze,
    input logic dbg_active,
    input logic unrecov
);
    a_r3_entry_needs_global: assert property (@(posedge clk) disable iff (rst)
        dbg_entry |-> $past(glob_en));

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(dbg_entry && int_take));

    a_r4_entry_freezes: assert property (@(posedge clk) disable iff (rst)
        dbg_entry |-> (freeze && dbg_active));

    a_r8_unrecov_in_debug: assert property (@(posedge clk) disable iff (rst)
        unrecov |-> dbg_active);

    a_r10_exit_clears: assert property (@(posedge clk) disable iff (rst)
        $past(exit_dbg) |-> (!dbg_active && !freeze && !unrecov));

    a_r12_quiet_in_debug: assert property (@(posedge clk) disable iff (rst)
        ($past(dbg_active) || $past(exit_dbg)) |-> (!dbg_entry && !int_take));
endmodule

bind dbg_entry_ctl dbg_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .glob_en   (glob_en),
    .exit_dbg  (exit_dbg),
    .dbg_entry (dbg_entry),
    .int_take  (int_take),
    .freeze    (freeze),
    .dbg_active(dbg_active),
    .unrecov   (unrecov)
);

// File: tb/sim_dbg_entry_ctl.sv
module sim_dbg_entry_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NEV = 19;
    localparam int CW  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NEV-2:0] ev_req = '0;
    logic          msr_ee = 1'b0, msr_ri = 1'b0, bk_masked = 1'b0;
    logic          glob_en = 1'b1, dbg_pin = 1'b0, der_wr = 1'b0;
    logic [NEV-1:0] der_wdata = '0;
    logic          exit_dbg = 1'b0;
    logic [CW-1:0] cause_clr = '0;
    logic          dbg_entry, int_take, freeze, dbg_active, unrecov;
    logic [NEV-1:0] der_q;
    logic [CW-1:0] cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_entry_ctl u0 (
        .clk(clk), .rst(rst), .ev_req(ev_req), .msr_ee(msr_ee), .msr_ri(msr_ri),
        .bk_masked(bk_masked), .glob_en(glob_en), .dbg_pin(dbg_pin),
        .der_wr(der_wr), .der_wdata(der_wdata), .exit_dbg(exit_dbg),
        .cause_clr(cause_clr), .dbg_entry(dbg_entry), .int_take(int_take),
        .freeze(freeze), .dbg_active(dbg_active), .unrecov(unrecov),
        .der_q(der_q), .cause(cause)
    );

    typedef struct packed {
        logic [17:0] ev;
        logic        ee, ri, bkm, gen;
        logic        x_dbg, x_int, x_frz;
        logic [4:0]  x_idx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{18'h00001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1 },  // R8 nmi
        '{18'h00002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd2 },  // R3 R4 gen off
        '{18'h00080, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0 },  // R5 ext masked
        '{18'h00080, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd8 },  // R5 ext on
        '{18'h01800, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd13},  // R5 dec ignored
        '{18'h08000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0 },  // R6 masked, ri=0
        '{18'h08000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd16},  // R6 unmasked
        '{18'h10000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd17},  // R6 masked, ri=1
        '{18'h20000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0 },  // R7 ri=0
        '{18'h20000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd18},  // R7 ri=1
        '{18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd1 },  // R9 R8 all
        '{18'h00104, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3 },  // R9 mchk
        '{18'h06000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd14}   // R9 trace
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        @(negedge clk);
        ev_req = '0;
        exit_dbg = 1'b1;
        cause_clr = '1;
        tick();
        @(negedge clk);
        exit_dbg = 1'b0;
        cause_clr = '0;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        dbg_pin = pin;
        tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) tick();
        chk("R1 flags", {27'd0, dbg_entry, int_take, freeze, dbg_active, unrecov}, 32'd0);
        chk("R1 der", 32'(der_q), 32'h7FFFF);
        chk("R1 cause", cause, 32'd0);

        // R2: window with pin high
        @(negedge clk);
        dbg_pin = 1'b1;
        rst = 1'b0;
        repeat (6) tick();
        chk("R2 early", {30'd0, dbg_entry, int_take}, 32'd0);
        tick();
        chk("R2 entry", {30'd0, dbg_entry, dbg_active}, 32'd3);
        chk("R2 cause pin", cause, 32'h8000_0001);
        chk("R4 freeze reset entry", 32'(freeze), 32'd1);

        // R12: request ignored while debug active
        @(negedge clk);
        ev_req = 18'h00001;
        tick();
        chk("R12 no strobe", {30'd0, dbg_entry, int_take}, 32'd0);
        chk("R12 cause kept", cause, 32'h8000_0001);
        clear_all();
        chk("R10 exit", {29'd0, dbg_active, freeze, unrecov}, 32'd0);

        // R2: window with pin low
        do_reset(1'b0);
        repeat (7) tick();
        chk("R2 pin low", {29'd0, dbg_entry, int_take, freeze}, 32'd2);
        chk("R2 cause low", cause, 32'h0000_0001);
        tick();
        chk("R2 single", 32'(int_take), 32'd0);
        clear_all();

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] xc;
            @(negedge clk);
            ev_req    = VECS[v].ev;
            msr_ee    = VECS[v].ee;
            msr_ri    = VECS[v].ri;
            bk_masked = VECS[v].bkm;
            glob_en   = VECS[v].gen;
            tick();
            xc = (VECS[v].x_dbg || VECS[v].x_int) ? (32'd1 << VECS[v].x_idx) : 32'd0;
            chk($sformatf("R3 R9 vec%0d strobes", v), {29'd0, dbg_entry, int_take, freeze},
                {29'd0, VECS[v].x_dbg, VECS[v].x_int, VECS[v].x_frz});
            chk($sformatf("R5 R6 R7 vec%0d cause", v), cause, xc);
            chk($sformatf("R8 vec%0d unrecov", v), 32'(unrecov),
                32'(VECS[v].x_dbg && VECS[v].x_idx == 5'd1));
            clear_all();
            chk($sformatf("R10 vec%0d cleared", v), {29'd0, dbg_active, freeze, unrecov}, 32'd0);
        end

        // R11: set and clear in the same cycle
        @(negedge clk);
        msr_ee = 1'b0; msr_ri = 1'b0; bk_masked = 1'b0;
        glob_en = 1'b0;
        ev_req = 18'h00002;
        tick();
        chk("R11 first bit", cause, 32'h0000_0004);
        @(negedge clk);
        ev_req = 18'h01000;
        cause_clr = '1;
        tick();
        chk("R11 set wins", cause, 32'h0000_2000);
        @(negedge clk);
        ev_req = '0;
        cause_clr = '0;
        tick();
        chk("R4 freeze held", 32'(freeze), 32'd1);
        clear_all();

        // R13: enable register write, then R3 disabled bit
        @(negedge clk);
        glob_en = 1'b1;
        der_wr = 1'b1;
        der_wdata = 19'h7FFFD;
        tick();
        @(negedge clk);
        der_wr = 1'b0;
        chk("R13 der", 32'(der_q), 32'h7FFFD);
        ev_req = 18'h00001;
        tick();
        chk("R3 der off", {29'd0, dbg_entry, int_take, freeze}, 32'd2);
        chk("R8 no unrecov", 32'(unrecov), 32'd0);
        clear_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule